// File: doc/BRIEF.md
# Bus-Clocked I2C Target With Address Wake

This block is the target (slave) side of a two-wire I2C link. It needs no bit clock of its own. A free-running system clock oversamples the SCL and SDA lines, and every bus event is taken from edges seen on those lines: START, STOP, rising SCL and falling SCL. The block compares the first byte after a START with a programmable own address. That address is either 7 bits wide or 10 bits wide. Optionally the block also accepts the general-call address. When the address matches, the block acknowledges it and pulses an event that can wake a sleeping system.

After a match, bytes move through two one-byte streams. Written bytes leave on a valid/ready receive stream. Once `rx_valid` rises, `rx_data` holds still until `rx_ready` takes it. A new byte cannot enter until the buffer is free. For a read, the block raises `tx_ready` each time it needs a byte and copies `tx_data` on the cycle where `tx_valid` and `tx_ready` are both high. The consumer applies back-pressure by holding `rx_ready` low, and the producer does it by holding `tx_valid` low. In both cases the block holds SCL low on the bus until the stream moves on.

Both bus outputs are pull-low enables. A 1 on an output means "drive the line low" and a 0 means "release the line". The block never drives a line high.

Top module: `i2c_addr_slave`

## Requirements
- R1: In 7-bit mode (`ten_bit_mode`=0), a first byte whose bits [7:1] equal `own_addr[6:0]` is acknowledged by pulling SDA low during the ninth clock, and `evt_match` pulses once. Any other first byte is left unacknowledged.
- R2: In 10-bit mode, a first byte of 11110 followed by `own_addr[9:8]` and a write bit (R/W=0) is acknowledged. The full match and `evt_match` need a second byte equal to `own_addr[7:0]`. In 10-bit mode a byte that matches only the 7-bit form is not acknowledged.
- R3: In 10-bit mode, after a full 10-bit match, a repeated START followed by the same first byte with R/W=1 is acknowledged and enters read mode with no second byte. This is refused after a STOP or a mismatch.
- R4: With `gcall_en`=1, the first byte 0x00 is acknowledged and pulses both `evt_match` and `evt_gcall`. With `gcall_en`=0, that byte is not acknowledged in 7-bit mode.
- R5: After an address that is not acknowledged, the block ignores the bus until the next START. It pulls neither line low and delivers no receive byte.
- R6: `evt_start` pulses on SDA falling while SCL is high, and `evt_stop` pulses on SDA rising while SCL is high. `busy` is 1 from a START until a STOP.
- R7: Each written data byte is acknowledged and then presented on `rx_data`, most significant bit first as received. `rx_valid` and `rx_data` hold steady until `rx_ready`.
- R8: After the ACK of a written byte, if the receive buffer still holds an untaken byte, SCL is held low until that byte is taken.
- R9: For a read, each byte is taken through the tx handshake and shifted out most significant bit first. A master ACK (SDA low on the ninth clock) fetches the next byte. A master NACK releases SDA and ends the read.
- R10: In a read, when a byte is needed and `tx_valid` is low, SCL is held low and `tx_ready` stays high until a byte is supplied. `tx_ready` is low at other times.
- R11: After reset, and at any time `busy` is 0, both `scl_pull` and `sda_pull` are 0.
- R12: `is_read` equals the R/W bit of the most recently matched address (0 for a general call).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low (stretch) |
| sda_pull | output | 1 | 1 pulls SDA low |
| own_addr | input | 10 | Own address; bits [6:0] used in 7-bit mode |
| ten_bit_mode | input | 1 | 1 selects 10-bit address compare |
| gcall_en | input | 1 | 1 accepts the general-call address |
| tx_data | input | 8 | Byte offered for a read |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Block is waiting for a read byte |
| rx_data | output | 8 | Received write byte |
| rx_valid | output | 1 | rx_data holds an untaken byte |
| rx_ready | input | 1 | Consumer takes rx_data |
| evt_start | output | 1 | One-cycle pulse on START |
| evt_stop | output | 1 | One-cycle pulse on STOP |
| evt_match | output | 1 | One-cycle pulse on a full address match (wake event) |
| evt_gcall | output | 1 | One-cycle pulse on a general-call match |
| busy | output | 1 | Bus transaction in progress |
| is_read | output | 1 | R/W bit of the last matched address |

## Verification
The address stage is driven with a table of first and second bytes that covers every compare path:
- an exact 7-bit hit and a one-bit-off miss;
- 0x00 with general call enabled and with it disabled;
- a 10-bit hit, a 10-bit hit on the first byte followed by a wrong second byte, and a wrong high-address prefix;
- a 7-bit-shaped byte presented while in 10-bit mode.

Together these show whether acknowledge and the match events follow the selected mode or leak across modes. The data paths use distinct byte values so that a bit-order or byte-order error is visible:
- a write with an always-ready consumer, against one with a stalled consumer;
- a read with a ready producer, against one with a late producer;
- a 10-bit read reached through a repeated START, against the same read byte sent after a STOP.

The stalled and late cases show whether SCL stretching tracks the buffer state. The repeated-START pair shows whether the remembered 10-bit match is kept across a repeated START and dropped at a STOP.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 10;
  localparam int CNT_W   = $clog2(BYTE_W + 2);
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ADDR2,
    ST_WRITE,
    ST_READ
  } slv_state_t;

  typedef struct packed {
    logic hit;    // acknowledge this address byte
    logic need2;  // 10-bit first byte: a second byte follows
    logic rd;     // matched with R/W = 1
    logic gcall;  // general-call hit
  } match_t;
endpackage

// File: rtl/i2c_slv_line_sync.sv
module i2c_slv_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;
  logic [LINES-1:0] din, cur, prev;

  assign din = {sda_in, scl_in};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], din[i]};
    end
    assign cur[i]  = sh[STAGES-1];
    assign prev[i] = sh[STAGES];
  end

  assign scl_lvl   = cur[0];
  assign sda_lvl   = cur[1];
  assign scl_rise  = cur[0] & ~prev[0];
  assign scl_fall  = ~cur[0] & prev[0];
  assign start_det = cur[0] & prev[0] & prev[1] & ~cur[1];
  assign stop_det  = cur[0] & prev[0] & ~prev[1] & cur[1];
endmodule

// File: rtl/i2c_slv_addr_match.sv
module i2c_slv_addr_match
  import i2c_slv_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              second_i,
  input  logic              had10_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ten_bit_mode,
  input  logic              gcall_en,
  output match_t            res_o
);
  always_comb begin
    res_o = '0;
    if (second_i) begin
      res_o.hit = (byte_i == own_addr[BYTE_W-1:0]);
    end else if (gcall_en && byte_i == '0) begin
      res_o.hit   = 1'b1;
      res_o.gcall = 1'b1;
    end else if (!ten_bit_mode) begin
      res_o.hit = (byte_i[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
      res_o.rd  = byte_i[0];
    end else if (byte_i[7:3] == TEN_PREFIX && byte_i[2:1] == own_addr[ADDR_W-1:BYTE_W]) begin
      if (!byte_i[0]) begin
        res_o.hit   = 1'b1;
        res_o.need2 = 1'b1;
      end else if (had10_i) begin
        res_o.hit = 1'b1;
        res_o.rd  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2c_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ten_bit_mode,
  input  logic              gcall_en,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              evt_start,
  output logic              evt_stop,
  output logic              evt_match,
  output logic              evt_gcall,
  output logic              busy,
  output logic              is_read
);
  localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(BYTE_W + 1);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;
  slv_state_t        state;
  logic [BYTE_W-1:0] shreg, rx_buf;
  logic [CNT_W-1:0]  bitcnt;
  logic ack_ph, hand_rx, pend, sda_q, had10, rd_q, busy_q, rx_v, mack;
  match_t mres;

  i2c_slv_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(ev_start), .stop_det(ev_stop)
  );

  i2c_slv_addr_match u_match (
    .byte_i(shreg), .second_i(state == ST_ADDR2), .had10_i(had10),
    .own_addr(own_addr), .ten_bit_mode(ten_bit_mode), .gcall_en(gcall_en),
    .res_o(mres)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; shreg <= '0; rx_buf <= '0; bitcnt <= '0;
      ack_ph <= 1'b0; hand_rx <= 1'b0; pend <= 1'b0; sda_q <= 1'b0;
      had10 <= 1'b0; rd_q <= 1'b0; busy_q <= 1'b0; rx_v <= 1'b0; mack <= 1'b0;
      evt_start <= 1'b0; evt_stop <= 1'b0; evt_match <= 1'b0; evt_gcall <= 1'b0;
    end else begin
      evt_start <= 1'b0; evt_stop <= 1'b0; evt_match <= 1'b0; evt_gcall <= 1'b0;
      if (rx_v && rx_ready) rx_v <= 1'b0;
      if (ev_start) begin
        state <= ST_ADDR1; bitcnt <= '0; ack_ph <= 1'b0; pend <= 1'b0;
        sda_q <= 1'b0; busy_q <= 1'b1; evt_start <= 1'b1;
      end else if (ev_stop) begin
        state <= ST_IDLE; bitcnt <= '0; ack_ph <= 1'b0; pend <= 1'b0;
        sda_q <= 1'b0; busy_q <= 1'b0; had10 <= 1'b0; evt_stop <= 1'b1;
      end else if (ack_ph) begin
        // end of our ACK clock: release SDA, then hand over or fetch
        if (scl_fall) begin
          ack_ph <= 1'b0; sda_q <= 1'b0; bitcnt <= '0;
          pend   <= hand_rx || (state == ST_READ);
        end
      end else begin
        case (state)
          ST_ADDR1, ST_ADDR2, ST_WRITE: begin
            if (pend) begin
              if (!rx_v || rx_ready) begin
                rx_buf <= shreg; rx_v <= 1'b1; pend <= 1'b0;
              end
            end else if (scl_rise && bitcnt < BYTE_CNT) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == BYTE_CNT) begin
              if (state == ST_WRITE) begin
                ack_ph <= 1'b1; sda_q <= 1'b1; hand_rx <= 1'b1;
              end else if (mres.hit) begin
                ack_ph <= 1'b1; sda_q <= 1'b1; hand_rx <= 1'b0;
                if (mres.need2) begin
                  state <= ST_ADDR2;
                end else begin
                  state     <= mres.rd ? ST_READ : ST_WRITE;
                  rd_q      <= mres.rd;
                  evt_match <= 1'b1;
                  evt_gcall <= mres.gcall;
                  if (state == ST_ADDR2) had10 <= 1'b1;
                end
              end else begin
                state <= ST_IDLE; had10 <= 1'b0;
              end
            end
          end
          ST_READ: begin
            if (pend) begin
              if (tx_valid) begin
                shreg <= tx_data; sda_q <= ~tx_data[BYTE_W-1]; pend <= 1'b0;
              end
            end else if (scl_rise) begin
              if (bitcnt < BYTE_CNT)     bitcnt <= bitcnt + 1'b1;
              else if (bitcnt == ACK_CNT) mack  <= ~sda_lvl;
            end else if (scl_fall) begin
              if (bitcnt == ACK_CNT) begin
                if (mack) begin pend <= 1'b1; bitcnt <= '0; end
                else state <= ST_IDLE;
              end else if (bitcnt == BYTE_CNT) begin
                sda_q <= 1'b0; bitcnt <= ACK_CNT;
              end else if (bitcnt != '0) begin
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                sda_q <= ~shreg[BYTE_W-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_pull = pend;
  assign sda_pull = sda_q;
  assign tx_ready = pend && (state == ST_READ);
  assign rx_valid = rx_v;
  assign rx_data  = rx_buf;
  assign busy     = busy_q;
  assign is_read  = rd_q;
endmodule

// File: rtl/i2c_slv_checker.sv
module i2c_slv_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       evt_start,
  input logic       evt_stop,
  input logic       evt_match,
  input logic       busy
);
  a_r1_match_acks: assert property (@(posedge clk) disable iff (!rst_n)
    evt_match |-> sda_pull);
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |-> busy);
  a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |-> !busy);
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  a_r8_stretch_full: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && !tx_ready && rx_valid && !rx_ready) |=> scl_pull);
  a_r10_tx_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> tx_ready);
  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sda_pull && !scl_pull));
endmodule

bind i2c_addr_slave i2c_slv_checker u_chk (.*);

// File: tb/i2c_addr_slave_bench.sv
module i2c_addr_slave_bench;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_pull, sda_pull, scl_line, sda_line;
  assign scl_line = !(m_scl_low || scl_pull);
  assign sda_line = !(m_sda_low || sda_pull);

  logic [9:0] own_addr = 10'h03A;
  logic ten_bit_mode = 1'b0, gcall_en = 1'b0, tx_en = 1'b0, rx_ready = 1'b1;
  logic [7:0] tx_list [4];
  logic [2:0] tx_idx = '0;
  logic [7:0] tx_data, rx_data;
  logic tx_valid, tx_ready, rx_valid;
  logic evt_start, evt_stop, evt_match, evt_gcall, busy, is_read;
  assign tx_valid = tx_en && (tx_idx < 3'd4);
  assign tx_data  = tx_list[tx_idx[1:0]];

  i2c_addr_slave u_i2c_addr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(own_addr),
    .ten_bit_mode(ten_bit_mode), .gcall_en(gcall_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .evt_start(evt_start), .evt_stop(evt_stop), .evt_match(evt_match),
    .evt_gcall(evt_gcall), .busy(busy), .is_read(is_read)
  );

  int n_chk = 0, n_err = 0;
  int n_start = 0, n_stop = 0, n_match = 0, n_gc = 0, rx_n = 0;
  logic [7:0] rx_log [8];

  initial forever begin
    @(posedge clk);
    if (evt_start) n_start++;
    if (evt_stop)  n_stop++;
    if (evt_match) n_match++;
    if (evt_gcall) n_gc++;
    if (rx_valid && rx_ready) begin rx_log[rx_n[2:0]] = rx_data; rx_n++; end
    if (tx_valid && tx_ready) tx_idx <= tx_idx + 3'd1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b1; wclk(Q); m_scl_low = 1'b1; wclk(Q);
  endtask

  task automatic m_rstart();
    m_sda_low = 1'b0; wclk(Q); m_scl_low = 1'b0; wait_scl_high(); wclk(Q);
    m_sda_low = 1'b1; wclk(Q); m_scl_low = 1'b1; wclk(Q);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; wclk(Q); m_scl_low = 1'b0; wait_scl_high(); wclk(Q);
    m_sda_low = 1'b0; wclk(2*Q);
  endtask

  task automatic mbit_w(input logic b);
    m_sda_low = !b; wclk(Q); m_scl_low = 1'b0; wait_scl_high(); wclk(2*Q);
    m_scl_low = 1'b1; wclk(Q);
  endtask

  task automatic mbit_r(output logic b);
    m_sda_low = 1'b0; wclk(Q); m_scl_low = 1'b0; wait_scl_high(); wclk(Q);
    b = sda_line; wclk(Q); m_scl_low = 1'b1; wclk(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) mbit_w(d[i]);
    mbit_r(b);
    ack = !b;
  endtask

  task automatic m_rbyte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) mbit_r(d[i]);
    mbit_w(!ack);
  endtask

  // {ten, gcall_en, own[9:0], byte1, byte2, ack1, ack2, gcall_expected}
  localparam logic [30:0] VEC [8] = '{
    {1'b0, 1'b0, 10'h03A, 8'h74, 8'h00, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 10'h03A, 8'h76, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 10'h03A, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1},
    {1'b0, 1'b0, 10'h03A, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h2C5, 8'hF4, 8'hC5, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 10'h2C5, 8'hF4, 8'hC4, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h2C5, 8'hF2, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h03A, 8'h74, 8'h00, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int m0, g0, s0, p0, r0;
    tx_list[0] = 8'hA5; tx_list[1] = 8'h3C; tx_list[2] = 8'h96; tx_list[3] = 8'h4B;
    wclk(5); rst_n = 1'b1; wclk(5);

    // R11 reset state
    chk("R11 scl_pull after reset", scl_pull, 0);
    chk("R11 sda_pull after reset", sda_pull, 0);
    chk("R6 busy after reset", busy, 0);
    chk("R7 rx_valid after reset", rx_valid, 0);
    chk("R10 tx_ready after reset", tx_ready, 0);

    // address table: R1 R2 R4 R5
    for (int i = 0; i < 8; i++) begin
      logic [30:0] v;
      v = VEC[i];
      ten_bit_mode = v[30]; gcall_en = v[29]; own_addr = v[28:19];
      m0 = n_match; g0 = n_gc;
      m_start();
      m_wbyte(v[18:11], ack);
      chk(v[30] ? "R2 first byte ack" : "R1 R4 address ack", ack, v[2]);
      if (v[30] && v[2]) begin
        m_wbyte(v[10:3], ack);
        chk("R2 second byte ack", ack, v[1]);
      end
      m_stop();
      chk("R1 R2 match event count", n_match - m0, v[30] ? (v[2] & v[1]) : v[2]);
      chk("R4 general call event count", n_gc - g0, v[0]);
    end
    ten_bit_mode = 1'b0; gcall_en = 1'b0; own_addr = 10'h03A;

    // R6 R7 write with ready consumer
    s0 = n_start; p0 = n_stop; r0 = rx_n;
    m_start(); wclk(5);
    chk("R6 busy after START", busy, 1);
    m_wbyte(8'h74, ack);
    chk("R12 is_read after write address", is_read, 0);
    m_wbyte(8'h5A, ack); chk("R7 data ack", ack, 1);
    m_wbyte(8'hC3, ack); chk("R7 data ack", ack, 1);
    m_stop(); wclk(5);
    chk("R6 busy after STOP", busy, 0);
    chk("R6 start events", n_start - s0, 1);
    chk("R6 stop events", n_stop - p0, 1);
    chk("R7 bytes delivered", rx_n - r0, 2);
    chk("R7 first byte", rx_log[r0[2:0]], 8'h5A);
    chk("R7 second byte", rx_log[r0[2:0] + 3'd1], 8'hC3);

    // R8 stretch on full receive buffer
    rx_ready = 1'b0; r0 = rx_n;
    m_start();
    m_wbyte(8'h74, ack);
    m_wbyte(8'h11, ack);
    m_wbyte(8'h22, ack);
    wclk(8);
    chk("R8 SCL held while buffer full", scl_pull, 1);
    chk("R7 buffered byte valid", rx_valid, 1);
    chk("R7 buffered byte", rx_data, 8'h11);
    wclk(30);
    chk("R8 SCL still held", scl_pull, 1);
    rx_ready = 1'b1; wclk(1); rx_ready = 1'b0; wclk(5);
    chk("R8 SCL released after take", scl_pull, 0);
    chk("R7 next byte", rx_data, 8'h22);
    rx_ready = 1'b1;
    m_stop(); wclk(2);
    chk("R7 stalled pair delivered", rx_n - r0, 2);
    chk("R7 stalled first", rx_log[r0[2:0]], 8'h11);

    // R9 R12 read with ready producer
    tx_idx = 3'd0; tx_en = 1'b1;
    m_start();
    m_wbyte(8'h75, ack); chk("R9 read address ack", ack, 1);
    chk("R12 is_read after read address", is_read, 1);
    m_rbyte(d, 1'b1); chk("R9 first read byte", d, 8'hA5);
    m_rbyte(d, 1'b0); chk("R9 second read byte", d, 8'h3C);
    wclk(Q);
    chk("R9 SDA released after NACK", sda_pull, 0);
    m_stop();
    chk("R9 bytes taken", tx_idx, 2);

    // R10 stretch on empty transmit
    tx_en = 1'b0;
    m_start();
    m_wbyte(8'h75, ack);
    wclk(10);
    chk("R10 SCL held while tx empty", scl_pull, 1);
    chk("R10 tx_ready while waiting", tx_ready, 1);
    tx_en = 1'b1; wclk(5);
    chk("R10 tx_ready after handshake", tx_ready, 0);
    m_rbyte(d, 1'b0); chk("R10 late byte", d, 8'h96);
    m_stop();

    // R3 10-bit read through repeated START
    ten_bit_mode = 1'b1; own_addr = 10'h2C5;
    m_start();
    m_wbyte(8'hF4, ack);
    m_wbyte(8'hC5, ack);
    m_rstart();
    m_wbyte(8'hF5, ack); chk("R3 repeated-start read ack", ack, 1);
    chk("R12 is_read after 10-bit read", is_read, 1);
    m_rbyte(d, 1'b0); chk("R3 10-bit read byte", d, 8'h4B);
    m_stop();
    m_start();
    m_wbyte(8'hF5, ack); chk("R3 read refused after STOP", ack, 0);
    m_stop();

    // R5 ignore after unmatched address
    ten_bit_mode = 1'b0; own_addr = 10'h03A; r0 = rx_n;
    m_start();
    m_wbyte(8'h20, ack); chk("R5 unmatched address", ack, 0);
    m_wbyte(8'hFF, ack); chk("R5 data ignored", ack, 0);
    chk("R5 no buffered byte", rx_valid, 0);
    m_stop();
    chk("R5 nothing delivered", rx_n - r0, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule